// File: doc/BRIEF.md
# Two-Bit Symbol Triplet Counter

This block takes an 18-bit word and reads it as nine 2-bit symbols. It counts how often any of three three-symbol patterns occurs among those symbols. A start pulse captures the word from a parallel bus. The block then consumes it one bit per clock, most significant bit first. Bits are paired into symbols on even bit boundaries. A small state machine follows the three patterns through their common first symbol. Each completed pattern raises a one-cycle pulse and increments a saturating count. A done flag marks the point where all 18 bits have been consumed.

The symbols are A = 00, B = 01, C = 10 and D = 11. The three patterns are B-A-A, B-A-D and B-D-A, which are the bit strings 010000, 010011 and 011100. No pattern ends in B, so two matches can never overlap. After each hit the detector goes back to its idle state.

Top module: `sym_triplet_counter`

## Requirements
- R1: A synchronous active-high reset drives `hit`, `hit_count` and `done` to zero and returns all internal state to idle.
- R2: A start pulse captures `frame_in` and clears the count, the pulse and the done flag. One bit is consumed on each of the 18 rising edges that follow the start edge, most significant bit first.
- R3: Symbol k (k = 0..8) is `frame_in[17-2k -: 2]`, and its first consumed bit is its most significant bit. The encoding is A=00, B=01, C=10, D=11. A pattern that straddles a symbol boundary (odd bit offset) is not counted.
- R4: `hit` goes high after the rising edge that consumes the second bit of the third symbol of a B-A-A, B-A-D or B-D-A run. For a run ending at symbol k, that is edge 2k+2 counted from the start edge.
- R5: The first symbol of the patterns is shared. A B received in any non-final position restarts matching, so B-B-D-A is counted once. A C after B, or any symbol that cannot continue a pattern, returns the detector to idle.
- R6: `hit_count` increases by one on the same edge on which `hit` rises. Otherwise it holds, except when start clears it.
- R7: `hit_count` saturates at 2^CNT_W-1 and never wraps within a frame.
- R8: `done` rises on the 18th edge after the start edge and stays high until the next start. While it is high, no hit occurs and the count does not change.
- R9: A start during a frame abandons that frame. Its partial match and its count do not carry into the new frame.
- R10: `hit` is high for exactly one cycle per match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Captures the word and begins a frame |
| frame_in | input | 2*FRAME_SYMS (18) | Word to scan, symbol 0 in the top bits |
| hit | output | 1 | One-cycle pulse per detected pattern |
| hit_count | output | CNT_W (4) | Saturating number of hits in the current frame |
| done | output | 1 | High once all bits of the frame are consumed |

## Verification
The start edge is edge 0. The bit consumed on edge n is bit 18-n of the word. The pulse and the count for a pattern ending at symbol k are due right after edge 2k+2, and `done` is due right after edge 18. The bench samples every output on the falling edge that follows each of those 18 rising edges. It compares them with a reference that checks every aligned three-symbol window of the word against the three bit strings. It also holds a few idle cycles after done to confirm that nothing moves. A second instance with a one-bit count is run on the same stimulus to show saturation at the end of each frame.

// File: rtl/sym_det_pkg.sv
package sym_det_pkg;

  typedef logic [1:0] sym_t;

  localparam sym_t SYM_A = 2'b00;
  localparam sym_t SYM_B = 2'b01;
  localparam sym_t SYM_C = 2'b10;
  localparam sym_t SYM_D = 2'b11;

  typedef enum logic [1:0] {ST_IDLE, ST_B, ST_BA, ST_BD} trip_st_e;

  typedef struct packed {
    trip_st_e nxt;
    logic     match;
  } step_t;

  // One symbol step of the shared-prefix matcher.
  function automatic step_t trip_step(trip_st_e cur, sym_t s);
    step_t r;
    r.match = 1'b0;
    r.nxt   = (s == SYM_B) ? ST_B : ST_IDLE;
    case (cur)
      ST_B: begin
        if (s == SYM_A)      r.nxt = ST_BA;
        else if (s == SYM_D) r.nxt = ST_BD;
      end
      ST_BA: begin
        if (s == SYM_A || s == SYM_D) begin
          r.match = 1'b1;
          r.nxt   = ST_IDLE;
        end
      end
      ST_BD: begin
        if (s == SYM_A) begin
          r.match = 1'b1;
          r.nxt   = ST_IDLE;
        end
      end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sym_frame_shifter.sv
module sym_frame_shifter #(
  parameter int FRAME_W = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               ser_bit,
  output logic               bit_odd,
  output logic               busy,
  output logic               done
);
  localparam int IDX_W = $clog2(FRAME_W + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sreg_q;
  logic [IDX_W-1:0]   idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
      idx_q  <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else if (start) begin
      sreg_q <= frame_in;
      idx_q  <= '0;
      busy   <= 1'b1;
      done   <= 1'b0;
    end else if (busy) begin
      sreg_q <= {sreg_q[FRAME_W-2:0], 1'b0};
      idx_q  <= idx_q + IDX_W'(1);
      if (idx_q == LAST_IDX) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assign ser_bit = sreg_q[FRAME_W-1];
  assign bit_odd = idx_q[0];

endmodule

// File: rtl/sym_pair_assembler.sv
module sym_pair_assembler
  import sym_det_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic busy,
  input  logic bit_odd,
  input  logic ser_bit,
  output sym_t sym,
  output logic sym_vld
);
  logic hi_q;

  always_ff @(posedge clk) begin
    if (rst || start)             hi_q <= 1'b0;
    else if (busy && !bit_odd)    hi_q <= ser_bit;
  end

  assign sym_vld = busy && bit_odd;
  assign sym     = {hi_q, ser_bit};

endmodule

// File: rtl/sym_triplet_fsm.sv
module sym_triplet_fsm
  import sym_det_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic sym_vld,
  input  sym_t sym,
  output logic match_now,
  output logic hit
);
  trip_st_e st_q;
  step_t    step;

  assign step      = trip_step(st_q, sym);
  assign match_now = sym_vld && step.match;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      st_q <= ST_IDLE;
      hit  <= 1'b0;
    end else begin
      hit <= match_now;
      if (sym_vld) st_q <= step.nxt;
    end
  end

endmodule

// File: rtl/sym_hit_counter.sv
module sym_hit_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || start)               cnt <= '0;
    else if (inc && cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
  end

endmodule

// File: rtl/sym_triplet_counter.sv
module sym_triplet_counter
  import sym_det_pkg::*;
#(
  parameter int FRAME_SYMS = 9,
  parameter int CNT_W      = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [2*FRAME_SYMS-1:0] frame_in,
  output logic                    hit,
  output logic [CNT_W-1:0]        hit_count,
  output logic                    done
);
  localparam int FRAME_W = 2 * FRAME_SYMS;

  logic ser_bit;
  logic bit_odd;
  logic busy;
  sym_t sym;
  logic sym_vld;
  logic match_now;

  sym_frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .start(start), .frame_in(frame_in),
    .ser_bit(ser_bit), .bit_odd(bit_odd), .busy(busy), .done(done)
  );

  sym_pair_assembler u_pair (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .bit_odd(bit_odd), .ser_bit(ser_bit), .sym(sym), .sym_vld(sym_vld)
  );

  sym_triplet_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .sym_vld(sym_vld), .sym(sym),
    .match_now(match_now), .hit(hit)
  );

  sym_hit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .start(start), .inc(match_now), .cnt(hit_count)
  );

endmodule

// File: rtl/sym_triplet_chk.sv
module sym_triplet_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             hit,
  input logic [CNT_W-1:0] hit_count,
  input logic             done,
  input logic             busy,
  input logic             sym_vld
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  p_hit_single_r10: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);

  p_hit_on_symbol_r4: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(sym_vld));

  p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
    (hit_count != $past(hit_count)) |->
      ((hit && hit_count == $past(hit_count) + CNT_W'(1)) ||
       ($past(start) && hit_count == '0)));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(hit_count) == CMAX && !$past(start)) |-> hit_count == CMAX);

  p_done_end_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(busy) && !busy));

  p_quiet_after_done_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (!hit && $stable(hit_count)));

  p_start_clears_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> (!hit && hit_count == '0 && !done && busy));

endmodule

bind sym_triplet_counter sym_triplet_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .hit(hit), .hit_count(hit_count),
  .done(done), .busy(busy), .sym_vld(sym_vld)
);

// File: tb/sym_triplet_counter_tb.sv
`timescale 1ns/1ps
module sym_triplet_counter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [17:0] frame_in = '0;
  logic        hit;
  logic [3:0]  hit_count;
  logic        done;
  logic        s_hit;
  logic [0:0]  s_count;
  logic        s_done;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sym_triplet_counter u_dut (
    .clk(clk), .rst(rst), .start(start), .frame_in(frame_in),
    .hit(hit), .hit_count(hit_count), .done(done)
  );

  sym_triplet_counter #(.CNT_W(1)) u_dut_sat (
    .clk(clk), .rst(rst), .start(start), .frame_in(frame_in),
    .hit(s_hit), .hit_count(s_count), .done(s_done)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference: window of three aligned symbols ending at symbol k.
  function automatic bit win_hit(logic [17:0] w, int k);
    logic [5:0] t;
    if (k < 2) return 1'b0;
    t = w[17 - 2*(k-2) -: 6];
    return (t == 6'b010000) || (t == 6'b010011) || (t == 6'b011100);
  endfunction

  function automatic int hits_upto(logic [17:0] w, int k);
    int n = 0;
    for (int i = 0; i <= k; i++) if (win_hit(w, i)) n++;
    return n;
  endfunction

  task automatic pulse_start(logic [17:0] w);
    @(negedge clk);
    frame_in = w;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_frame(logic [17:0] w, string req);
    int total;
    pulse_start(w);
    for (int n = 1; n <= 18; n++) begin
      int k;
      @(posedge clk);
      @(negedge clk);
      k = n / 2 - 1;
      chk(req, "hit (R4)", int'(hit), ((n % 2) == 0) ? int'(win_hit(w, k)) : 0);
      chk(req, "count (R6)", int'(hit_count), (k < 0) ? 0 : hits_upto(w, k));
      chk(req, "done (R8)", int'(done), (n == 18) ? 1 : 0);
    end
    total = hits_upto(w, 8);
    chk(req, "saturated count (R7)", int'(s_count), (total > 1) ? 1 : total);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(req, "idle hit (R8)", int'(hit), 0);
      chk(req, "idle count (R8)", int'(hit_count), total);
      chk(req, "idle done (R8)", int'(done), 1);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "hit", int'(hit), 0);
    chk("R1", "count", int'(hit_count), 0);
    chk("R1", "done", int'(done), 0);
    rst = 1'b0;
  endtask

  task automatic t_restart();
    // Frame with a hit, abandoned after 8 bits while a B is pending (R9).
    pulse_start(18'b011100_010000_000000);
    repeat (7) @(negedge clk);
    chk("R9", "partial count before restart", int'(hit_count), 1);
    run_frame(18'b111000_000000_000000, "R9");
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    run_frame(18'h00000, "R2");                          // all A, no hit
    run_frame(18'b011100_000000_000000, "R4");           // B D A at start
    run_frame(18'b010000_010011_011100, "R6");           // three hits in a row
    run_frame(18'b000000_000000_010011, "R4");           // hit on last symbol
    run_frame(18'b0_011100_00000000000, "R3");           // odd offset, not counted
    run_frame(18'b01011100_0000000000, "R5");            // B B D A restart
    run_frame(18'b011000_011111_010010, "R5");           // near misses
    run_frame(18'b0100010000_00000000, "R5");            // B A B A A
    run_frame(18'h3FFFF, "R3");                          // all D
    run_frame(18'b010101_010101_010101, "R10");          // all B
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule